// File: doc/BRIEF.md
# Clock Output Controller

This block puts one of six on-chip clocks onto a single clock-output pin. Software writes a small control word that holds a source code and an enable bit, and reads back the same word with two status flags: busy and ready. While the output is in use, the block asks for the chosen source to be kept running through a one-hot request vector. Start and stop are handled without glitches, even when the chosen clock is far slower than the CPU clock.

The enable request is carried into the selected clock's domain through a synchroniser. An output gate opens or closes only while that clock is low. The gate state is synchronised back to the CPU clock, and the status flags follow it. Busy goes high the cycle after a valid enable write. It locks the source code and blocks a fresh enable until the whole shutdown is over. Ready goes high once the gate has been seen open. Both flags stay high after a disable until the closed gate has been seen again in the CPU domain.

Top module: `clkout_ctrl`

## Requirements
- R1: After reset the read word is all zeros (enable 0, select 0, busy 0, ready 0), `osc_req` is zero and `clk_out` is low.
- R2: The select codes 0, 1, 2, 3, 4 and 5 pick `src_clk[0]` to `src_clk[5]`. These are, in that order: external fast oscillator, internal fast oscillator, divided internal fast clock, internal slow oscillator, master clock and prescaled CPU clock. Once ready is 1, `clk_out` equals the selected source.
- R3: Read-word layout: bit 0 enable, bits 4:1 select, bit 5 busy, bit 6 ready. The write word is bit 0 enable and bits 4:1 select. A write with enable 1 and a code below 6, made while busy is 0, sets busy in the next CPU cycle. From then until busy clears, `osc_req` is one-hot with bit i set for code i, and the enable bit implies busy.
- R4: Ready rises only after the output gate has opened, and ready is never 1 while busy is 0.
- R5: While busy is 1, the select field of a write is ignored: the read-back code and the output source stay unchanged.
- R6: A write with enable 1 and a select code of 6 to 15 stores the code but is refused. Enable and busy stay 0, `osc_req` stays zero and `clk_out` stays low.
- R7: A write with enable 0 starts shutdown. Busy and ready stay 1 until the closed gate has come back through the synchroniser; with the slow source this is still true 10 CPU cycles later. The two flags then clear in the same cycle, and `osc_req` returns to zero.
- R8: Every high pulse on `clk_out` lasts exactly half a period of the selected source, and `clk_out` is low whenever busy is 0.
- R9: A write with enable 1 during shutdown is ignored. After busy clears, the enable bit reads 0 and busy stays 0.
- R10: A disable issued before the output has started still completes cleanly. The gate opens once (ready goes high), then closes, and the block returns to idle with enable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; register and status logic |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 5 | Write word: bit 0 enable, bits 4:1 select |
| reg_rdata | output | 7 | Read word: bit 0 enable, bits 4:1 select, bit 5 busy, bit 6 ready |
| src_clk | input | NUM_SRC (6) | Candidate source clocks, index equals select code |
| osc_req | output | NUM_SRC (6) | One-hot keep-running request for the selected source while busy |
| clk_out | output | 1 | Gated clock for the output pin |

## Verification
The bench targets the slow internal source during shutdown. A design that dropped busy on the disable write, or before the closed gate had come back through the synchroniser, would show idle flags while the pin still toggled. It checks the width of every output high pulse, so a gate that switched while the clock was high would show up as a short pulse. It tries select changes and re-enables while busy, and disables during start-up. A design missing the write lock would jump sources mid-stream, and one with a weak shutdown handshake would either hang busy or leave the gate open. Unassigned select codes are also driven to confirm that they never start the output.

// File: rtl/clkout_pkg.sv
`timescale 1ns/100ps
// Package: shared constants and the control state type for the clock output
// controller. Assumes at most 16 sources (4-bit select field).
package clkout_pkg;
    localparam int CO_NUM_SRC  = 6;
    localparam int CO_SEL_W    = 4;
    localparam int CO_WR_W     = 1 + CO_SEL_W;
    localparam int CO_RD_W     = CO_WR_W + 2;
    localparam int CO_EN_BIT   = 0;
    localparam int CO_SEL_LSB  = 1;
    localparam int CO_BUSY_BIT = CO_WR_W;
    localparam int CO_RDY_BIT  = CO_WR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2,
        ST_STOP  = 2'd3
    } co_state_e;
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/100ps
// Module: single-bit level synchroniser of STAGES flops.
// ASYNC_RST picks an asynchronous reset, for clock domains that may be
// stopped while reset is applied; otherwise the reset is synchronous.
// Assumes STAGES >= 2 and a level input that is stable for several clocks.
module clkout_sync #(
    parameter int STAGES    = 2,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (ASYNC_RST) begin : g_async
            // Shift chain, cleared at once by reset.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end else begin : g_sync
            // Shift chain, cleared on a clock edge during reset.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/clkout_src_mux.sv
`timescale 1ns/100ps
// Module: combinational source clock selector. Codes at or above NUM_SRC
// give a constant low. Assumes the caller changes sel only while the
// downstream gate is closed, so switching glitches never reach the pin.
module clkout_src_mux #(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_o
);
    // Pick the source whose index equals the select code.
    always_comb begin
        clk_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) clk_o = src_clk[i];
        end
    end
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/100ps
// Module: output gate living in the selected clock's domain. The request
// is synchronised on rising edges, and the gate flop updates on falling
// edges, so it only changes while the clock is low and no partial pulse
// can appear. Assumes the request is a level held until the gate follows.
module clkout_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic req,
    output logic gate,
    output logic clk_out
);
    logic req_s;

    clkout_sync #(
        .STAGES    (SYNC_STAGES),
        .ASYNC_RST (1'b1)
    ) u_req_sync (
        .clk   (sclk),
        .rst_n (rst_n),
        .d     (req_s_in()),
        .q     (req_s)
    );

    function automatic logic req_s_in();
        return req;
    endfunction

    // Open or close the gate only on a falling edge of the selected clock.
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) gate <= 1'b0;
        else        gate <= req_s;
    end

    assign clk_out = sclk & gate;
endmodule

// File: rtl/clkout_ctl.sv
`timescale 1ns/100ps
// Module: CPU-domain control word and start/stop sequencer. It holds the
// enable and select fields and applies the write lock while busy. It
// drives the level request to the gate and tracks the gate state
// synchronised back from the source domain. Assumes gate_seen is already
// synchronous to clk.
module clkout_ctl
    import clkout_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             gate_seen,
    output logic             req,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             busy,
    output logic             ready
);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_SRC);

    co_state_e state;
    logic      sel_ok;
    logic      start_ok;

    assign sel_ok   = (wr_sel < SEL_LIMIT);
    assign start_ok = wr_en && wr_enable && sel_ok;

    // Control fields: free writes when idle; when busy only clearing enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (state == ST_IDLE) begin
                sel_q <= wr_sel;
                en_q  <= wr_enable && sel_ok;
            end else begin
                en_q  <= en_q && wr_enable;
            end
        end
    end

    // Sequencer: idle -> start -> run -> stop -> idle, paced by the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ready <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:  if (start_ok) state <= ST_START;
                ST_START: if (gate_seen) begin
                              ready <= 1'b1;
                              state <= en_q ? ST_RUN : ST_STOP;
                          end
                ST_RUN:   if (!en_q) state <= ST_STOP;
                ST_STOP:  if (!gate_seen) begin
                              ready <= 1'b0;
                              state <= ST_IDLE;
                          end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign req  = (state == ST_START) || (state == ST_RUN);
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/100ps
// Module: top of the clock output controller. It joins the CPU-domain
// sequencer, the source selector, the source-domain gate and the return
// synchroniser, and drives the one-hot keep-running request for the
// selected source while busy. Assumes src_clk entries are free-running
// when requested and NUM_SRC <= 16.
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int NUM_SRC     = CO_NUM_SRC,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [CO_WR_W-1:0] reg_wdata,
    output logic [CO_RD_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic [NUM_SRC-1:0] osc_req,
    output logic               clk_out
);
    logic                req;
    logic                en_q;
    logic [CO_SEL_W-1:0] sel_q;
    logic                busy;
    logic                ready;
    logic                gate_src;
    logic                gate_seen;
    logic                mux_clk;

    clkout_ctl #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (CO_SEL_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_enable (reg_wdata[CO_EN_BIT]),
        .wr_sel    (reg_wdata[CO_SEL_LSB +: CO_SEL_W]),
        .gate_seen (gate_seen),
        .req       (req),
        .en_q      (en_q),
        .sel_q     (sel_q),
        .busy      (busy),
        .ready     (ready)
    );

    clkout_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (CO_SEL_W)
    ) u_mux (
        .src_clk (src_clk),
        .sel     (sel_q),
        .clk_o   (mux_clk)
    );

    clkout_gate #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_gate (
        .sclk    (mux_clk),
        .rst_n   (rst_n),
        .req     (req),
        .gate    (gate_src),
        .clk_out (clk_out)
    );

    clkout_sync #(
        .STAGES    (SYNC_STAGES),
        .ASYNC_RST (1'b0)
    ) u_back_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_src),
        .q     (gate_seen)
    );

    // Keep-running request: one bit per source, held for the busy period.
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_req
            assign osc_req[g] = busy && (sel_q == CO_SEL_W'(g));
        end
    endgenerate

    assign reg_rdata[CO_EN_BIT]                 = en_q;
    assign reg_rdata[CO_SEL_LSB +: CO_SEL_W]    = sel_q;
    assign reg_rdata[CO_BUSY_BIT]               = busy;
    assign reg_rdata[CO_RDY_BIT]                = ready;
endmodule

// File: rtl/clkout_ctrl_chk.sv
`timescale 1ns/100ps
// Module: property checker for the clock output controller, observing only
// its ports. Attached to every instance of the top by the bind below.
module clkout_ctrl_chk #(
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [4:0]         reg_wdata,
    input logic [6:0]         reg_rdata,
    input logic [NUM_SRC-1:0] osc_req,
    input logic               clk_out
);
    logic       en_b;
    logic       busy_b;
    logic       rdy_b;
    logic [3:0] sel_b;

    assign en_b   = reg_rdata[0];
    assign sel_b  = reg_rdata[4:1];
    assign busy_b = reg_rdata[5];
    assign rdy_b  = reg_rdata[6];

    // R4: ready never stands without busy.
    p_ready_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_b |-> busy_b);

    // R3: the enable bit implies busy.
    p_enable_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_b |-> busy_b);

    // R3: busy begins only from an enable write.
    p_start_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_b) |-> $past(reg_we && reg_wdata[0]));

    // R3: exactly one source request is raised while busy.
    p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_b |-> ($countones(osc_req) == 1));

    // R5: the select field is locked for the whole busy period.
    p_sel_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_b && $past(busy_b)) |-> $stable(sel_b));

    // R6: an unassigned code never starts the output.
    p_refuse_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[0] && (reg_wdata[4:1] >= 4'(NUM_SRC)) && !busy_b)
        |=> !busy_b);

    // R7: busy and ready drop together, and the request drops with them.
    p_flags_fall_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_b) |-> ($fell(rdy_b) && (osc_req == '0)));

    // R7: no request while idle.
    p_no_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_b |-> (osc_req == '0));

    // R8: the pin is quiet while idle.
    p_pin_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_b |-> !clk_out);
endmodule

bind clkout_ctrl clkout_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .osc_req   (osc_req),
    .clk_out   (clk_out)
);

// File: tb/clkout_ctrl_bench.sv
`timescale 1ns/100ps
// Bench: a vector table walk over all six sources, then directed tests.
module clkout_ctrl_bench;
    localparam int NSRC = 6;
    localparam int HALF_NS [0:NSRC-1] = '{7, 15, 30, 250, 11, 20};
    localparam logic [3:0] ALT_SEL [0:NSRC-1] = '{4'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4};
    localparam int SLOW_IDX = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [4:0]      reg_wdata = '0;
    logic [6:0]      reg_rdata;
    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] osc_req;
    logic            clk_out;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, s4 = 1'b0, s5 = 1'b0;

    int  n_chk = 0;
    int  n_bad = 0;
    int  runt_cnt = 0;
    real exp_half = 0.0;
    real t_rise = 0.0;

    always #10 clk = ~clk;
    always #(HALF_NS[0]) s0 = ~s0;
    always #(HALF_NS[1]) s1 = ~s1;
    always #(HALF_NS[2]) s2 = ~s2;
    always #(HALF_NS[3]) s3 = ~s3;
    always #(HALF_NS[4]) s4 = ~s4;
    always #(HALF_NS[5]) s5 = ~s5;
    assign src_clk = {s5, s4, s3, s2, s1, s0};

    clkout_ctrl u_clkout_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_clk   (src_clk),
        .osc_req   (osc_req),
        .clk_out   (clk_out)
    );

    // R8 pulse monitor: every high pulse must last one source half period.
    always @(posedge clk_out) t_rise = $realtime;
    always @(negedge clk_out) begin
        if (exp_half > 0.0) begin
            if (($realtime - t_rise) < exp_half - 0.05 ||
                ($realtime - t_rise) > exp_half + 0.05)
                runt_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [3:0] sel, input logic en);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = {sel, en};
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_ready(input int max, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < max; k++) begin
            @(negedge clk);
            if (reg_rdata[6]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_idle(input int max, output bit ok, output bit saw_rdy);
        ok = 1'b0;
        saw_rdy = 1'b0;
        for (int k = 0; k < max; k++) begin
            @(negedge clk);
            if (reg_rdata[6]) saw_rdy = 1'b1;
            if (!reg_rdata[5]) begin ok = 1'b1; break; end
        end
    endtask

    // Compares the pin with a source (s < 0 means expect low), off all edges.
    task automatic match_clk(input int s, input int n, output int mism);
        mism = 0;
        @(negedge clk);
        #0.5;
        for (int k = 0; k < n; k++) begin
            if (s < 0) begin
                if (clk_out !== 1'b0) mism++;
            end else if (clk_out !== src_clk[s]) begin
                mism++;
            end
            #7;
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok, saw;
        int mism, r0;

        // R1: reset state.
        repeat (5) @(negedge clk);
        check(reg_rdata == 7'd0, "R1 read word", reg_rdata, 0);
        check(osc_req == '0, "R1 osc_req", osc_req, 0);
        check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(reg_rdata == 7'd0, "R1 after release", reg_rdata, 0);

        // Table walk over every source.
        for (int i = 0; i < NSRC; i++) begin
            exp_half = real'(HALF_NS[i]);
            r0 = runt_cnt;
            reg_write(4'(i), 1'b1);
            check(reg_rdata[5] == 1'b1, "R3 busy next cycle", reg_rdata[5], 1);
            check(osc_req == NSRC'(1 << i), "R3 osc_req one-hot", osc_req, 1 << i);
            wait_ready(4000, ok);
            check(ok, "R4 ready after gate opens", ok, 1);
            match_clk(i, 80, mism);
            check(mism == 0, "R2 pin follows source", mism, 0);
            reg_write(ALT_SEL[i], 1'b1);
            check(reg_rdata[4:1] == 4'(i), "R5 select locked", reg_rdata[4:1], i);
            match_clk(i, 40, mism);
            check(mism == 0, "R5 source unchanged", mism, 0);
            check(osc_req == NSRC'(1 << i), "R3 request held", osc_req, 1 << i);
            reg_write(4'(i), 1'b0);
            check(reg_rdata[6:5] == 2'b11, "R7 flags held on disable", reg_rdata[6:5], 3);
            if (i == SLOW_IDX) begin
                reg_write(4'(i), 1'b1);
                repeat (8) @(negedge clk);
                check(reg_rdata[6:5] == 2'b11, "R7 flags held slow", reg_rdata[6:5], 3);
            end
            wait_idle(4000, ok, saw);
            check(ok, "R7 shutdown completes", ok, 1);
            check(reg_rdata[6:5] == 2'b00, "R7 flags clear together", reg_rdata[6:5], 0);
            check(osc_req == '0, "R7 request dropped", osc_req, 0);
            if (i == SLOW_IDX) begin
                repeat (3) @(negedge clk);
                check(reg_rdata[0] == 1'b0, "R9 re-enable ignored", reg_rdata[0], 0);
                check(reg_rdata[5] == 1'b0, "R9 stays idle", reg_rdata[5], 0);
            end
            match_clk(-1, 60, mism);
            check(mism == 0, "R8 pin low when idle", mism, 0);
            check(runt_cnt == r0, "R8 pulse widths", runt_cnt - r0, 0);
        end

        // R6: unassigned codes refused.
        reg_write(4'd9, 1'b1);
        check(reg_rdata == {2'b00, 4'd9, 1'b0}, "R6 code 9 refused", reg_rdata, 18);
        check(osc_req == '0, "R6 no request", osc_req, 0);
        reg_write(4'd6, 1'b1);
        check(reg_rdata == {2'b00, 4'd6, 1'b0}, "R6 code 6 refused", reg_rdata, 12);
        match_clk(-1, 40, mism);
        check(mism == 0, "R6 pin low", mism, 0);

        // R10: disable during start-up on the slow source.
        exp_half = real'(HALF_NS[SLOW_IDX]);
        r0 = runt_cnt;
        reg_write(4'(SLOW_IDX), 1'b1);
        reg_write(4'(SLOW_IDX), 1'b0);
        check(reg_rdata[5] == 1'b1, "R10 busy after early disable", reg_rdata[5], 1);
        wait_idle(4000, ok, saw);
        check(ok, "R10 returns idle", ok, 1);
        check(saw, "R10 ready seen", saw, 1);
        check(reg_rdata[0] == 1'b0, "R10 enable cleared", reg_rdata[0], 0);
        check(runt_cnt == r0, "R8 pulse widths early stop", runt_cnt - r0, 0);

        // R2: a new start after all of the above still works.
        exp_half = real'(HALF_NS[1]);
        reg_write(4'd1, 1'b1);
        wait_ready(4000, ok);
        match_clk(1, 40, mism);
        check(ok && mism == 0, "R2 restart", mism, 0);
        reg_write(4'd1, 1'b0);
        wait_idle(4000, ok, saw);
        check(ok, "R7 final shutdown", ok, 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule